// File: doc/BRIEF.md
# G.711 Sample Compander

This block sits in the word path of a synchronous serial port. Outgoing 16-bit linear PCM words are compressed to 8-bit G.711 codes, and incoming 8-bit codes are expanded back to 16-bit linear samples. Each direction has its own enable and its own choice of law, either μ-law or A-law. When a direction's enable is low, its word passes through untouched.

The conversion is pure segment-and-mantissa logic with no lookup memory. The compressed or expanded word is valid in the same cycle as its input, so turning companding on does not change the timing of the serial word path. A build parameter can add one output register stage. That stage exists only for timing closure and is not part of the normal datapath.

Law select encoding, per direction: 0 selects μ-law and 1 selects A-law. A compressed code sits in bits [7:0] of the outgoing word, with bits [15:8] zero. On receive, only bits [7:0] of the incoming word are decoded when expansion is on.

Top module: `g711_compander`

## Requirements
- R1: With transmit μ-law on, the encoder works as follows. It takes lin[15:2] as a 14-bit signed value v. The magnitude is |v| for v ≥ 0 and −v for v < 0. It adds 33 to the magnitude and takes segment s = (bit position of the leading one) − 5, with s = 0 below 64. The mantissa is bits [s+4:s+1]. The code is the bitwise inverse of {negative, s, mantissa}. Examples: 0→0x00FF, 1000→0x00CE, −1000→0x004E.
- R2: With transmit μ-law on, magnitudes above 8159 are clamped to 8159 before encoding. Any positive input of 32632 or more yields 0x0080, and −32768 yields 0x0000.
- R3: With transmit A-law on, the encoder works as follows. It takes lin[15:3] as a 13-bit signed value v. The magnitude is v for v ≥ 0 and −v−1 for v < 0. Segment 0 holds magnitudes below 32, with mantissa m[4:1]. Otherwise s = (leading-one position) − 4 and the mantissa is m[s+3:s]. The code is {nonnegative, s, mantissa} XOR 0x55. Examples: 0→0x00D5, −8→0x0055, 32760→0x00AA.
- R4: With receive μ-law on, the decoder works as follows. It inverts the code. It forms t = ((mantissa·8) + 132) << segment and outputs t − 132, negated when inverted bit 7 is set. Examples: 0xFF→0, 0x80→32124, 0x00→−32124.
- R5: With receive A-law on, the decoder works as follows. It XORs the code with 0x55. Segment 0 gives mantissa·16 + 8. Segment s > 0 gives (mantissa·16 + 264) << (s−1). The result is negated when bit 7 of the XORed code is clear. Examples: 0xD5→8, 0x55→−8, 0xAA→32256.
- R6: A direction whose enable is low outputs its input word unchanged in every bit. This holds whatever the other direction is doing.
- R7: The law of the transmit direction and the law of the receive direction are chosen independently and may differ at the same time.
- R8: With the default build, each output follows its inputs in the same cycle with no clock edge in between. With the registered build, each output takes its value at the next rising clock edge and is zero while reset is asserted.
- R9: With transmit companding on, bits [15:8] of the output are zero. Bit 7 is 1 for a nonnegative input and 0 for a negative input, under either law.
- R10: With receive companding on, the output lies within ±32256. Bits [1:0] are zero under μ-law and bits [2:0] are zero under A-law.
- R11: Linear input bits below the selected law's precision (lin[1:0] for μ-law, lin[2:0] for A-law) are ignored. Received bits [15:8] are ignored while expansion is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rstN | input | 1 | Active-low asynchronous reset |
| txEnable | input | 1 | Compress outgoing words when high |
| txLawSel | input | 1 | Transmit law: 0 μ-law, 1 A-law |
| txLinear | input | 16 | Outgoing linear two's-complement sample |
| txWord | output | 16 | Outgoing word: code in [7:0], or the sample when bypassed |
| rxEnable | input | 1 | Expand incoming words when high |
| rxLawSel | input | 1 | Receive law: 0 μ-law, 1 A-law |
| rxWord | input | 16 | Incoming word: code in [7:0] |
| rxLinear | output | 16 | Expanded linear sample, or the word when bypassed |

## Verification
Every cycle, the assertions check the transmit code's sign bit and zero upper byte, μ-law saturation of large inputs, and bypass transparency. For the receive direction they check the A-law sign, the output range, the low-bit granularity of expanded samples, and that at most one law strobe is active per direction. Only the bench's scenarios can show the exact segment and mantissa values of each code. The same holds for the boundaries between segments, the independent mixing of laws across directions, and the insensitivity to sub-precision and upper-byte bits. The bench also shows the same-cycle response of the default build against the one-edge delay and reset clearing of the registered build.

// File: rtl/g711_cmp_pkg.sv
package g711_cmp_pkg;
  localparam int LIN_W   = 16;
  localparam int CODE_W  = 8;
  localparam int MU_DROP = 2;
  localparam int A_DROP  = 3;
  localparam int MU_W    = LIN_W - MU_DROP;
  localparam int A_W     = LIN_W - A_DROP;
  localparam int MU_BIAS = 33;
  localparam int MU_CLIP = 8159;
  localparam int MU_OFS  = MU_BIAS << MU_DROP;
  localparam int A_HALF  = 1 << A_DROP;
  localparam int A_KNEE  = 256 + A_HALF;
  localparam logic [CODE_W-1:0] A_FLIP = 8'h55;

  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} lawSel_e;

  typedef struct packed {
    logic txMu;
    logic txA;
    logic rxMu;
    logic rxA;
  } cmpStrb_t;
endpackage

// File: rtl/g711_cmp_ctrl.sv
module g711_cmp_ctrl
  import g711_cmp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     txEnable,
  input  logic     txLawSel,
  input  logic     rxEnable,
  input  logic     rxLawSel,
  output cmpStrb_t strb
);
  lawSel_e txLaw;
  lawSel_e rxLaw;

  assign txLaw = lawSel_e'(txLawSel);
  assign rxLaw = lawSel_e'(rxLawSel);

  always_comb begin
    strb.txMu = txEnable && (txLaw == LAW_MU);
    strb.txA  = txEnable && (txLaw == LAW_A);
    strb.rxMu = rxEnable && (rxLaw == LAW_MU);
    strb.rxA  = rxEnable && (rxLaw == LAW_A);
  end

  // R7: each direction picks at most one law, independently of the other
  assert_tx_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txMu, strb.txA}));
  assert_rx_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rxMu, strb.rxA}));
  // R6: a disabled direction raises no strobe
  assert_tx_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> !(strb.txMu || strb.txA));
endmodule

// File: rtl/g711_cmp_datapath.sv
module g711_cmp_datapath
  import g711_cmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
)(
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrb_t         strb,
  input  logic [LIN_W-1:0] txIn,
  input  logic [LIN_W-1:0] rxIn,
  output logic [LIN_W-1:0] txOut,
  output logic [LIN_W-1:0] rxOut
);
  localparam int PAD_W = LIN_W - CODE_W;

  function automatic logic [CODE_W-1:0] muCompress(input logic [LIN_W-1:0] lin);
    logic [MU_W-1:0] v;
    logic            neg;
    logic [MU_W:0]   ext;
    logic [MU_W:0]   mag;
    logic [MU_W:0]   sh;
    logic [2:0]      seg;
    logic [CODE_W-1:0] raw;
    v   = lin[LIN_W-1:MU_DROP];
    neg = v[MU_W-1];
    ext = {v[MU_W-1], v};
    mag = neg ? (~ext + 1'b1) : ext;
    if (mag > (MU_W+1)'(MU_CLIP)) mag = (MU_W+1)'(MU_CLIP);
    mag = mag + (MU_W+1)'(MU_BIAS);
    seg = '0;
    for (int i = 6; i <= MU_W - 2; i++) if (mag[i]) seg = 3'(i - 5);
    sh  = mag >> (int'(seg) + 1);
    raw = mag[MU_W-1] ? {neg, 7'h7F} : {neg, seg, sh[3:0]};
    return ~raw;
  endfunction

  function automatic logic [CODE_W-1:0] aCompress(input logic [LIN_W-1:0] lin);
    logic [A_W-1:0] v;
    logic           neg;
    logic [A_W-2:0] mag;
    logic [A_W-2:0] sh;
    logic [2:0]     seg;
    int             amt;
    v   = lin[LIN_W-1:A_DROP];
    neg = v[A_W-1];
    mag = neg ? ~v[A_W-2:0] : v[A_W-2:0];
    seg = '0;
    for (int i = 5; i <= A_W - 2; i++) if (mag[i]) seg = 3'(i - 4);
    amt = (seg < 3'd2) ? 1 : int'(seg);
    sh  = mag >> amt;
    return {~neg, seg, sh[3:0]} ^ A_FLIP;
  endfunction

  function automatic logic [LIN_W-1:0] muExpand(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] u;
    logic [LIN_W-1:0]  t;
    logic [LIN_W-1:0]  val;
    u   = ~code;
    t   = LIN_W'({u[3:0], 3'b000}) + LIN_W'(MU_OFS);
    t   = t << u[6:4];
    val = t - LIN_W'(MU_OFS);
    return u[7] ? (LIN_W'(0) - val) : val;
  endfunction

  function automatic logic [LIN_W-1:0] aExpand(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] a;
    logic [LIN_W-1:0]  base;
    logic [LIN_W-1:0]  t;
    a    = code ^ A_FLIP;
    base = LIN_W'({a[3:0], 4'b0000});
    if (a[6:4] == 3'd0) t = base + LIN_W'(A_HALF);
    else                t = (base + LIN_W'(A_KNEE)) << (a[6:4] - 3'd1);
    return a[7] ? t : (LIN_W'(0) - t);
  endfunction

  logic [LIN_W-1:0] txNext;
  logic [LIN_W-1:0] rxNext;

  always_comb begin
    txNext = txIn;
    if (strb.txMu)     txNext = {{PAD_W{1'b0}}, muCompress(txIn)};
    else if (strb.txA) txNext = {{PAD_W{1'b0}}, aCompress(txIn)};
  end

  always_comb begin
    rxNext = rxIn;
    if (strb.rxMu)     rxNext = muExpand(rxIn[CODE_W-1:0]);
    else if (strb.rxA) rxNext = aExpand(rxIn[CODE_W-1:0]);
  end

  if (REG_OUT) begin : gRegd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txOut <= '0;
        rxOut <= '0;
      end else begin
        txOut <= txNext;
        rxOut <= rxNext;
      end
    end
  end else begin : gComb
    assign txOut = txNext;
    assign rxOut = rxNext;

    // R6: disabled directions are transparent
    assert_tx_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.txMu || strb.txA) |-> txOut == txIn);
    assert_rx_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.rxMu || strb.rxA) |-> rxOut == rxIn);
    // R9: code sign tracks the input sign, upper byte cleared
    assert_tx_sign_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strb.txMu || strb.txA) |-> (txOut[CODE_W-1] == !txIn[LIN_W-1]) && (txOut[LIN_W-1:CODE_W] == '0));
    // R2: large positive inputs saturate to the top code
    assert_mu_sat_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strb.txMu && ($signed(txIn) >= 16'sd32632)) |-> txOut == 16'h0080);
    // R10: expanded range and granularity
    assert_rx_range_R10: assert property (@(posedge clk) disable iff (!rstN)
      (strb.rxMu || strb.rxA) |-> ($signed(rxOut) <= 16'sd32256) && ($signed(rxOut) >= -16'sd32256));
    assert_rx_grain_R10: assert property (@(posedge clk) disable iff (!rstN)
      strb.rxA |-> rxOut[A_DROP-1:0] == '0);
    // R5: A-law never expands to zero, so the sign is set by code bit 7
    assert_a_sign_R5: assert property (@(posedge clk) disable iff (!rstN)
      strb.rxA |-> rxOut[LIN_W-1] == !rxIn[CODE_W-1]);
  end
endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_cmp_pkg::*;
#(
  parameter bit REG_OUT = 1'b0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txEnable,
  input  logic        txLawSel,
  input  logic [15:0] txLinear,
  output logic [15:0] txWord,
  input  logic        rxEnable,
  input  logic        rxLawSel,
  input  logic [15:0] rxWord,
  output logic [15:0] rxLinear
);
  cmpStrb_t strb;

  g711_cmp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txEnable (txEnable),
    .txLawSel (txLawSel),
    .rxEnable (rxEnable),
    .rxLawSel (rxLawSel),
    .strb     (strb)
  );

  g711_cmp_datapath #(.REG_OUT(REG_OUT)) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .txIn  (txLinear),
    .rxIn  (rxWord),
    .txOut (txWord),
    .rxOut (rxLinear)
  );
endmodule

// File: tb/g711_compander_bench.sv
module g711_compander_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEnable = 1'b0;
  logic        txLawSel = 1'b0;
  logic [15:0] txLinear = 16'hFFFF;
  logic        rxEnable = 1'b0;
  logic        rxLawSel = 1'b0;
  logic [15:0] rxWord = 16'hFFFF;
  logic [15:0] txWord, rxLinear, txWordQ, rxLinearQ;
  int          checks = 0;
  int          mism = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  g711_compander u_g711_compander (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txLawSel(txLawSel),
    .txLinear(txLinear), .txWord(txWord), .rxEnable(rxEnable),
    .rxLawSel(rxLawSel), .rxWord(rxWord), .rxLinear(rxLinear));

  g711_compander #(.REG_OUT(1'b1)) uRegd (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txLawSel(txLawSel),
    .txLinear(txLinear), .txWord(txWordQ), .rxEnable(rxEnable),
    .rxLawSel(rxLawSel), .rxWord(rxWord), .rxLinear(rxLinearQ));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      mism++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {txEn, txA, rxEn, rxA, txLinear, txExpected, rxWord, rxExpected}
  localparam int NV = 20;
  localparam logic [67:0] VEC [NV] = '{
    {4'b1010, 16'h0000, 16'h00FF, 16'h00FF, 16'h0000}, // R1 R4
    {4'b1010, 16'hFFFC, 16'h007E, 16'h00CE, 16'h03DC}, // R1 R4
    {4'b1010, 16'h03E8, 16'h00CE, 16'h004E, 16'hFC24}, // R1 R4
    {4'b1010, 16'hFC18, 16'h004E, 16'h0080, 16'h7D7C}, // R1 R4
    {4'b1010, 16'h0078, 16'h00F0, 16'h0000, 16'h8284}, // R1 R4 segment edge
    {4'b1010, 16'h007C, 16'h00EF, 16'h007F, 16'h0000}, // R1 R4 segment edge
    {4'b1011, 16'h7FFC, 16'h0080, 16'h00D5, 16'h0008}, // R2 R5
    {4'b1011, 16'h8000, 16'h0000, 16'h0055, 16'hFFF8}, // R2 R5
    {4'b1011, 16'h7F78, 16'h0080, 16'h00AA, 16'h7E00}, // R2 R5
    {4'b1111, 16'h0000, 16'h00D5, 16'h002A, 16'h8200}, // R3 R5
    {4'b1111, 16'hFFF8, 16'h0055, 16'h00FA, 16'h03F0}, // R3 R5
    {4'b1111, 16'h00F8, 16'h00DA, 16'h00C5, 16'h0108}, // R3 R5 linear region top
    {4'b1111, 16'h0100, 16'h00C5, 16'h00DA, 16'h00F8}, // R3 R5 first log segment
    {4'b1110, 16'h7FF8, 16'h00AA, 16'h00CE, 16'h03DC}, // R3 R7
    {4'b1110, 16'h8000, 16'h002A, 16'h004E, 16'hFC24}, // R3 R7
    {4'b1100, 16'h03E8, 16'h00FA, 16'h1234, 16'h1234}, // R3 R6
    {4'b1100, 16'hFC18, 16'h007A, 16'hABCD, 16'hABCD}, // R3 R6
    {4'b0011, 16'hBEEF, 16'hBEEF, 16'h00FA, 16'h03F0}, // R6 R5
    {4'b1110, 16'h03EB, 16'h00FA, 16'hA5CE, 16'h03DC}, // R11
    {4'b1011, 16'h03EB, 16'h00CE, 16'h77DA, 16'h00F8}  // R11
  };
  localparam int TXREQ [NV] = '{1,1,1,1,1,1,2,2,2,3,3,3,3,3,3,3,3,6,11,11};
  localparam int RXREQ [NV] = '{4,4,4,4,4,4,5,5,5,5,5,5,5,7,7,6,6,5,11,11};

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      mism++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, mism);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] pre;
    // Reset: registered build clears, default build stays transparent (R8)
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 reset txWordQ", txWordQ, 16'h0000);
    check("R8 reset rxLinearQ", rxLinearQ, 16'h0000);
    check("R6 bypass during reset", txWord, 16'hFFFF);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {txEnable, txLawSel, rxEnable, rxLawSel} = VEC[i][67:64];
      txLinear = VEC[i][63:48];
      rxWord   = VEC[i][31:16];
      #1;
      check($sformatf("R%0d tx vec%0d", TXREQ[i], i), txWord, VEC[i][47:32]);
      check($sformatf("R%0d rx vec%0d", RXREQ[i], i), rxLinear, VEC[i][15:0]);
    end

    // R8: same-cycle response vs one-edge delay
    @(negedge clk);
    pre = txWordQ;
    txEnable = 1'b1; txLawSel = 1'b0; txLinear = 16'h0000;
    rxEnable = 1'b0; rxWord = 16'h5A5A;
    #1;
    check("R8 comb tx same cycle", txWord, 16'h00FF);
    check("R8 comb rx same cycle", rxLinear, 16'h5A5A);
    check("R8 registered holds before edge", txWordQ, pre);
    @(posedge clk); #1;
    check("R8 registered tx after edge", txWordQ, 16'h00FF);
    check("R8 registered rx after edge", rxLinearQ, 16'h5A5A);

    // R9: code sign and upper byte across a sweep, both laws
    for (int law = 0; law < 2; law++) begin
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        txEnable = 1'b1; txLawSel = law[0]; txLinear = 16'(i * 257);
        #1;
        check("R9 upper byte", {8'h00, txWord[15:8]}, 16'h0000);
        check("R9 sign bit", {15'd0, txWord[7]}, {15'd0, ~txLinear[15]});
      end
    end

    // R10: expansion range and granularity over all codes, both laws
    for (int law = 0; law < 2; law++) begin
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        rxEnable = 1'b1; rxLawSel = law[0]; rxWord = {8'h3C, 8'(c)};
        #1;
        check("R10 range", {15'd0, ($signed(rxLinear) <= 16'sd32256) && ($signed(rxLinear) >= -16'sd32256)}, 16'd1);
        if (law == 1) check("R10 A-law grain", {13'd0, rxLinear[2:0]}, 16'd0);
        else          check("R10 mu-law grain", {14'd0, rxLinear[1:0]}, 16'd0);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, mism);
    $finish;
  end
endmodule